// File: doc/BRIEF.md
# Three-Stage Fetch/Decode/Execute Pipeline Sequencer

This block sequences instructions through a small core's pipeline. It has three stages: fetch, decode and execute. A word-addressed program counter drives an instruction-memory read port. The memory must return the word for the presented address before the next rising clock edge. Each accepted fetch captures that word and advances the counter by one.

The decode stage turns the captured word into control fields: a store-class flag, a write-back enable and a destination register index. The execute stage holds one instruction at a time. When the instruction leaves execute, the stage raises a retire strobe together with the instruction's fetch address and its write-back request.

A store-class instruction stays in execute for one extra clock. During that clock the program counter, the fetch stage and the decode stage all hold. Everything else in the core, such as the data path, the registers and branching, is outside this block.

Top module: `pipe3_seq`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0, retire_o is 0 and wb_en_o is 0. After release, the first fetch uses address 0.
- R2: imem_addr_o presents the program counter. The counter advances by exactly one on every rising edge that follows a cycle with imem_req_o high, and holds otherwise.
- R3: After reset release, the first instruction retires (retire_o high, retire_pc_o = 0) in the clock period that follows the third rising edge. retire_o is low in every period before it.
- R4: With no store-class words, one instruction retires in every clock period after fill. retire_pc_o takes the values 0, 1, 2, ... in order.
- R5: A word with bit 15 set is store-class. It occupies execute for two clock periods and retires only in the second. During the first, imem_req_o is low and imem_addr_o is unchanged.
- R6: Each store-class word delays its own retirement and the retirement of every later instruction by one clock. Instruction k retires after rising edge 3 + k + s. Here s is the number of store-class words among instructions 0..k. Single-cycle retirement resumes right after the stall.
- R7: On retirement, wb_en_o is 1 for a non-store word and 0 for a store-class word. wb_reg_o equals bits 3:0 of the retired word.
- R8: Back-to-back store-class words each cost one extra clock. A program made only of such words retires one instruction every two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 8 | Instruction fetch address (program counter) |
| imem_req_o | output | 1 | Fetch accepted this cycle (low during a stall) |
| imem_rdata_i | input | 16 | Instruction word for imem_addr_o |
| retire_o | output | 1 | An instruction leaves execute this cycle |
| retire_pc_o | output | 8 | Fetch address of the retiring instruction |
| wb_en_o | output | 1 | Retiring instruction writes its destination register |
| wb_reg_o | output | 4 | Destination register index of the retiring instruction |

## Verification
A corrupted valid bit shows up at retire_o within three clocks. The symptom is either a missing retirement in the fill window or an extra one. A wrong stall counter shows up on the very next clock. The symptoms are imem_req_o going low or high at the wrong time, a program counter step off by one, and every later retirement moving by the same offset. A decode fault in the store flag or the destination field appears on the clock that the affected instruction retires, through wb_en_o, wb_reg_o and the timing of the following retirement.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
  localparam int REG_W = 4;

  typedef struct packed {
    logic             store;
    logic             wb_en;
    logic [REG_W-1:0] dst;
  } dec_t;
endpackage

// File: rtl/pipe3_fetch.sv
module pipe3_fetch #(
  parameter int ADDR_W  = 8,
  parameter int INSTR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  output logic [ADDR_W-1:0]  imem_addr_o,
  output logic               imem_req_o,
  input  logic [INSTR_W-1:0] imem_rdata_i,
  output logic               f_valid_o,
  output logic [INSTR_W-1:0] f_instr_o,
  output logic [ADDR_W-1:0]  f_pc_o
);
  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      f_valid_o <= 1'b0;
      f_instr_o <= '0;
      f_pc_o    <= '0;
    end else if (!stall_i) begin
      pc_q      <= pc_q + ADDR_W'(1);
      f_valid_o <= 1'b1;
      f_instr_o <= imem_rdata_i;
      f_pc_o    <= pc_q;
    end
  end

  assign imem_addr_o = pc_q;
  assign imem_req_o  = !stall_i;

  // R2
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !imem_req_o |=> imem_addr_o == $past(imem_addr_o));

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o |=> imem_addr_o == $past(imem_addr_o) + ADDR_W'(1));
endmodule

// File: rtl/pipe3_decode.sv
module pipe3_decode
  import pipe3_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int INSTR_W   = 16,
  parameter int STORE_BIT = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  input  logic               f_valid_i,
  input  logic [INSTR_W-1:0] f_instr_i,
  input  logic [ADDR_W-1:0]  f_pc_i,
  output logic               d_valid_o,
  output dec_t               d_ctl_o,
  output logic [ADDR_W-1:0]  d_pc_o
);
  dec_t ctl_d;

  always_comb begin
    ctl_d.store = f_instr_i[STORE_BIT];
    ctl_d.wb_en = !f_instr_i[STORE_BIT];
    ctl_d.dst   = f_instr_i[REG_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_valid_o <= 1'b0;
      d_ctl_o   <= '0;
      d_pc_o    <= '0;
    end else if (!stall_i) begin
      d_valid_o <= f_valid_i;
      d_ctl_o   <= ctl_d;
      d_pc_o    <= f_pc_i;
    end
  end

  // R3
  fill_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_valid_o |-> f_valid_i);

  // R5
  dec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(d_pc_o));
endmodule

// File: rtl/pipe3_exec.sv
module pipe3_exec
  import pipe3_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STORE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d_valid_i,
  input  dec_t              d_ctl_i,
  input  logic [ADDR_W-1:0] d_pc_i,
  output logic              stall_o,
  output logic              retire_o,
  output logic [ADDR_W-1:0] retire_pc_o,
  output logic              wb_en_o,
  output logic [REG_W-1:0]  wb_reg_o
);
  localparam int CNT_W = (STORE_CYC > 2) ? $clog2(STORE_CYC) : 1;

  logic              x_valid_q;
  dec_t              x_ctl_q;
  logic [ADDR_W-1:0] x_pc_q;
  logic [CNT_W-1:0]  x_cnt_q;  // extra execute cycles still owed

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_valid_q <= 1'b0;
      x_ctl_q   <= '0;
      x_pc_q    <= '0;
      x_cnt_q   <= '0;
    end else if (stall_o) begin
      x_cnt_q <= x_cnt_q - CNT_W'(1);
    end else begin
      x_valid_q <= d_valid_i;
      x_ctl_q   <= d_ctl_i;
      x_pc_q    <= d_pc_i;
      x_cnt_q   <= (d_valid_i && d_ctl_i.store) ? CNT_W'(STORE_CYC - 1) : '0;
    end
  end

  assign stall_o     = x_valid_q && (x_cnt_q != '0);
  assign retire_o    = x_valid_q && (x_cnt_q == '0);
  assign retire_pc_o = x_pc_q;
  assign wb_en_o     = retire_o && x_ctl_q.wb_en;
  assign wb_reg_o    = x_ctl_q.dst;

  // R5
  store_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && d_valid_i && d_ctl_i.store) |=> !retire_o);

  // R4
  retire_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_o && $past(retire_o)) |-> retire_pc_o == $past(retire_pc_o) + ADDR_W'(1));

  // R3
  exec_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_valid_q |-> d_valid_i);
endmodule

// File: rtl/pipe3_seq.sv
module pipe3_seq
  import pipe3_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int INSTR_W   = 16,
  parameter int STORE_BIT = 15,
  parameter int STORE_CYC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [ADDR_W-1:0]  imem_addr_o,
  output logic               imem_req_o,
  input  logic [INSTR_W-1:0] imem_rdata_i,
  output logic               retire_o,
  output logic [ADDR_W-1:0]  retire_pc_o,
  output logic               wb_en_o,
  output logic [REG_W-1:0]   wb_reg_o
);
  logic               stall;
  logic               f_valid;
  logic [INSTR_W-1:0] f_instr;
  logic [ADDR_W-1:0]  f_pc;
  logic               d_valid;
  dec_t               d_ctl;
  logic [ADDR_W-1:0]  d_pc;

  pipe3_fetch #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_fetch (
    .clk_i, .rst_ni, .stall_i(stall),
    .imem_addr_o, .imem_req_o, .imem_rdata_i,
    .f_valid_o(f_valid), .f_instr_o(f_instr), .f_pc_o(f_pc)
  );

  pipe3_decode #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .STORE_BIT(STORE_BIT)) u_decode (
    .clk_i, .rst_ni, .stall_i(stall),
    .f_valid_i(f_valid), .f_instr_i(f_instr), .f_pc_i(f_pc),
    .d_valid_o(d_valid), .d_ctl_o(d_ctl), .d_pc_o(d_pc)
  );

  pipe3_exec #(.ADDR_W(ADDR_W), .STORE_CYC(STORE_CYC)) u_exec (
    .clk_i, .rst_ni,
    .d_valid_i(d_valid), .d_ctl_i(d_ctl), .d_pc_i(d_pc),
    .stall_o(stall), .retire_o, .retire_pc_o, .wb_en_o, .wb_reg_o
  );

  // R7
  wb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> retire_o);
endmodule

// File: tb/sim_pipe3_seq.sv
`timescale 1ns/1ps
module sim_pipe3_seq;
  localparam int NPAT  = 5;
  localparam int EDGES = 48;
  localparam int NINS  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr;
  logic        imem_req;
  logic [15:0] imem_rdata;
  logic        retire;
  logic [7:0]  retire_pc;
  logic        wb_en;
  logic [3:0]  wb_reg;
  logic [15:0] mem [256];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always_comb imem_rdata = mem[imem_addr];

  pipe3_seq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_addr_o(imem_addr), .imem_req_o(imem_req), .imem_rdata_i(imem_rdata),
    .retire_o(retire), .retire_pc_o(retire_pc), .wb_en_o(wb_en), .wb_reg_o(wb_reg)
  );

  function automatic bit is_store(int pat, int k);
    case (pat)
      0: return 1'b0;
      1: return (k % 3) == 2;
      2: return 1'b1;
      3: return (k % 2) == 1;
      default: return ((k * 7) % 5) == 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_pat(int pat);
    int t[NINS];
    int s = 0;
    int kn = 0;
    int stalls = 0;
    for (int k = 0; k < NINS; k++) begin
      mem[k] = {is_store(pat, k), 11'(k), 4'((k * 5) & 15)};
      if (is_store(pat, k)) s++;
      t[k] = 3 + k + s;
    end
    rst_n = 1'b0;
    @(negedge clk);
    // R1
    chk("R1", int'(imem_addr), 0, "reset addr");
    chk("R1", int'(retire), 0, "reset retire");
    chk("R1", int'(wb_en), 0, "reset wb_en");
    rst_n = 1'b1;
    for (int e = 1; e <= EDGES; e++) begin
      bit exp_ret;
      bit exp_stall;
      @(posedge clk);
      @(negedge clk);
      exp_ret = (t[kn] == e);
      exp_stall = 1'b0;
      for (int k = 0; k < NINS; k++)
        if (is_store(pat, k) && t[k] - 1 == e) exp_stall = 1'b1;
      for (int k = 0; k < NINS; k++)
        if (is_store(pat, k) && t[k] == e) stalls++;
      // R2: held edges equal stall periods completed
      chk("R2", int'(imem_addr), e - stalls, $sformatf("pat%0d e%0d addr", pat, e));
      // R5, R8: fetch request drops only during a store's extra cycle
      chk(pat == 2 ? "R8" : "R5", int'(imem_req), int'(!exp_stall),
          $sformatf("pat%0d e%0d req", pat, e));
      // R3, R4, R6: retirement timing
      chk(e <= 3 ? "R3" : (pat == 0 ? "R4" : "R6"), int'(retire), int'(exp_ret),
          $sformatf("pat%0d e%0d retire", pat, e));
      if (exp_ret && retire) begin
        chk("R4", int'(retire_pc), kn, $sformatf("pat%0d e%0d retire_pc", pat, e));
        // R7
        chk("R7", int'(wb_en), int'(!is_store(pat, kn)), $sformatf("pat%0d k%0d wb_en", pat, kn));
        chk("R7", int'(wb_reg), (kn * 5) & 15, $sformatf("pat%0d k%0d wb_reg", pat, kn));
      end
      if (exp_ret) kn++;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int p = 0; p < NPAT; p++) run_pat(p);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule